// File: doc/BRIEF.md
# Manchester Symbol Timing Counter

This block paces a Manchester receiver one symbol at a time. A cyclic state machine counts enabled clock cycles. At the last cycle of each symbol it emits a one-cycle data-clock pulse, and throughout the symbol it drives two single-bit reference waveforms, in-phase and quadrature, to an external I/Q correlator. A symbol normally lasts 16 enabled cycles.

A phase-error decoder downstream feeds back a 2-bit rate-adjust code. The code is read only in the decode state that closes a symbol, and it sets the length of the following symbol. It can stretch that symbol to 17 cycles by inserting a stretch state, or shorten it to 15 cycles by leaving out the last body state. Because the code is read only at that point, the data clock is realigned once per symbol and never part way through one.

The states are the body states `ST_P0` to `ST_P14`, the stretch state `ST_STRETCH` and the decode state `ST_DECODE`. The transitions are as follows:
- `ST_Pn` to `ST_Pn+1` for n from 0 to 12.
- `ST_P13` to `ST_DECODE` when the stored length is short, and to `ST_P14` otherwise.
- `ST_P14` to `ST_STRETCH` when the stored length is long, and to `ST_DECODE` otherwise.
- `ST_STRETCH` to `ST_DECODE`.
- `ST_DECODE` to `ST_P0`. On this transition the rate-adjust code is latched as the length of the next symbol.

Each transition takes place only on a clock edge at which `en` is high.

Top module: `mrx_symbol_timer`

## Requirements
- R1: A synchronous reset puts the machine in `ST_P0`, drives `sync_pulse`, `ref_i` and `ref_q` low, and sets the stored length to nominal (16 cycles).
- R2: While `en` is low the state does not advance, `ref_i` and `ref_q` hold their values and `sync_pulse` stays low.
- R3: Rate-adjust code 00 or 11 gives a symbol of 16 enabled cycles between successive `sync_pulse` assertions.
- R4: Rate-adjust code 01 gives a symbol of 17 enabled cycles.
- R5: Rate-adjust code 10 gives a symbol of 15 enabled cycles.
- R6: The rate-adjust code is sampled only on the enabled edge that leaves `ST_DECODE`. A change of the code during a symbol does not alter that symbol's length.
- R7: `sync_pulse` is high for exactly one cycle, in the cycle the machine is in `ST_DECODE`, and `ref_i` and `ref_q` are low in that cycle.
- R8: `ref_i` is high in symbol positions 0 to 7 (`ST_P0` to `ST_P7`) and low in every other state.
- R9: `ref_q` is high in symbol positions 4 to 11 (`ST_P4` to `ST_P11`) and low in every other state.
- R10: In a long symbol, the stretch state lies between position 14 and the decode state, and in it all three outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Clock enable for the counter |
| rate_adj | input | 2 | Rate-adjust code: 00 and 11 nominal, 01 long, 10 short |
| sync_pulse | output | 1 | Data-clock pulse, high in the decode state |
| ref_i | output | 1 | In-phase reference waveform |
| ref_q | output | 1 | Quadrature reference waveform |

## Verification
The bench measures the spacing between successive sync pulses for each of the four codes. A design that decodes a code wrongly, or that reads the code in the wrong place, produces 15, 16 and 17 in the wrong spots. It also changes the code just after a decode state, so a design that samples the code continuously shortens or stretches the current symbol instead of the next one. The waveforms are walked position by position in short, nominal and long symbols, which catches off-by-one quarter boundaries and a stretch state that leaks a high reference. An enable gap and a reset in mid-symbol expose a counter that runs while disabled, and a stored long length that survives reset.

// File: rtl/mrx_timing_pkg.sv
package mrx_timing_pkg;

    typedef enum logic [4:0] {
        ST_P0      = 5'd0,
        ST_P1      = 5'd1,
        ST_P2      = 5'd2,
        ST_P3      = 5'd3,
        ST_P4      = 5'd4,
        ST_P5      = 5'd5,
        ST_P6      = 5'd6,
        ST_P7      = 5'd7,
        ST_P8      = 5'd8,
        ST_P9      = 5'd9,
        ST_P10     = 5'd10,
        ST_P11     = 5'd11,
        ST_P12     = 5'd12,
        ST_P13     = 5'd13,
        ST_P14     = 5'd14,
        ST_STRETCH = 5'd15,
        ST_DECODE  = 5'd16
    } sym_state_e;

    typedef enum logic [1:0] {
        LEN_NOMINAL = 2'd0,
        LEN_LONG    = 2'd1,
        LEN_SHORT   = 2'd2
    } sym_len_e;

    // adjust code values on the rate_adj port
    localparam logic [1:0] ADJ_NOMINAL = 2'b00;
    localparam logic [1:0] ADJ_LONG    = 2'b01;
    localparam logic [1:0] ADJ_SHORT   = 2'b10;

    // default waveform quarter boundaries for a 16-cycle symbol
    localparam int unsigned NOM_LEN      = 16;
    localparam int unsigned I_HIGH_END   = NOM_LEN / 2;
    localparam int unsigned Q_HIGH_START = NOM_LEN / 4;
    localparam int unsigned Q_HIGH_END   = Q_HIGH_START + NOM_LEN / 2;

endpackage

// File: rtl/mrx_rate_latch.sv
module mrx_rate_latch
    import mrx_timing_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  sym_state_e state,
    input  logic [1:0] rate_adj,
    output sym_len_e   len_q
);

    logic     take_code;
    sym_len_e len_d;

    assign take_code = en && (state == ST_DECODE);

    always_comb begin
        unique case (rate_adj)
            ADJ_LONG:  len_d = LEN_LONG;
            ADJ_SHORT: len_d = LEN_SHORT;
            default:   len_d = LEN_NOMINAL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            len_q <= LEN_NOMINAL;
        end else if (take_code) begin
            len_q <= len_d;
        end
    end

    AST_LEN_ONLY_AT_DECODE: assert property (@(posedge clk) disable iff (rst)
        !(en && state == ST_DECODE) |=> $stable(len_q)) else $error("length changed outside decode"); // R6

    AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (rst)
        len_q != 2'd3) else $error("illegal length code"); // R3

endmodule

// File: rtl/mrx_state_seq.sv
module mrx_state_seq
    import mrx_timing_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  sym_len_e   len_q,
    output sym_state_e state,
    output sym_state_e state_nxt
);

    // next-state selection
    always_comb begin
        state_nxt = state;
        if (en) begin
            unique case (state)
                ST_P13:     state_nxt = (len_q == LEN_SHORT) ? ST_DECODE : ST_P14;
                ST_P14:     state_nxt = (len_q == LEN_LONG) ? ST_STRETCH : ST_DECODE;
                ST_STRETCH: state_nxt = ST_DECODE;
                ST_DECODE:  state_nxt = ST_P0;
                default:    state_nxt = sym_state_e'(state + 5'd1);
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_P0;
        end else begin
            state <= state_nxt;
        end
    end

    AST_FREEZE_IDLE: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(state)) else $error("state moved while disabled"); // R2

    AST_DECODE_RESTART: assert property (@(posedge clk) disable iff (rst)
        (en && state == ST_DECODE) |=> state == ST_P0) else $error("decode not followed by P0"); // R6

    AST_STRETCH_ONLY_LONG: assert property (@(posedge clk) disable iff (rst)
        state == ST_STRETCH |-> len_q == LEN_LONG) else $error("stretch in non-long symbol"); // R4

    AST_SHORT_SKIP: assert property (@(posedge clk) disable iff (rst)
        (en && state == ST_P13 && len_q == LEN_SHORT) |=> state == ST_DECODE) else $error("short symbol not cut"); // R5

endmodule

// File: rtl/mrx_wave_gen.sv
module mrx_wave_gen
    import mrx_timing_pkg::*;
#(
    parameter int unsigned I_END   = I_HIGH_END,
    parameter int unsigned Q_START = Q_HIGH_START,
    parameter int unsigned Q_END   = Q_HIGH_END
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  sym_state_e state_nxt,
    output logic       sync_pulse,
    output logic       ref_i,
    output logic       ref_q
);

    localparam int unsigned BODY_LAST = 14;

    logic i_d;
    logic q_d;
    logic body_d;
    int unsigned pos_d;

    assign pos_d  = int'(state_nxt);
    assign body_d = (pos_d <= BODY_LAST);
    assign i_d    = body_d && (pos_d < I_END);
    assign q_d    = body_d && (pos_d >= Q_START) && (pos_d < Q_END);

    // output registers, aligned with the state register
    always_ff @(posedge clk) begin
        if (rst) begin
            sync_pulse <= 1'b0;
            ref_i      <= 1'b0;
            ref_q      <= 1'b0;
        end else if (en) begin
            sync_pulse <= (state_nxt == ST_DECODE);
            ref_i      <= i_d;
            ref_q      <= q_d;
        end else begin
            sync_pulse <= 1'b0;
        end
    end

    AST_SYNC_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        sync_pulse |=> !sync_pulse) else $error("sync wider than one cycle"); // R7

    AST_SYNC_REFS_LOW: assert property (@(posedge clk) disable iff (rst)
        sync_pulse |-> (!ref_i && !ref_q)) else $error("reference high during decode"); // R7

    AST_REFS_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(ref_i) && $stable(ref_q) && !sync_pulse)) else $error("outputs moved while disabled"); // R2

endmodule

// File: rtl/mrx_symbol_timer.sv
module mrx_symbol_timer
    import mrx_timing_pkg::*;
#(
    parameter int unsigned I_END   = I_HIGH_END,
    parameter int unsigned Q_START = Q_HIGH_START,
    parameter int unsigned Q_END   = Q_HIGH_END
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic [1:0] rate_adj,
    output logic       sync_pulse,
    output logic       ref_i,
    output logic       ref_q
);

    sym_state_e state;
    sym_state_e state_nxt;
    sym_len_e   len_q;

    mrx_rate_latch u_latch (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .state    (state),
        .rate_adj (rate_adj),
        .len_q    (len_q)
    );

    mrx_state_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .len_q     (len_q),
        .state     (state),
        .state_nxt (state_nxt)
    );

    mrx_wave_gen #(
        .I_END   (I_END),
        .Q_START (Q_START),
        .Q_END   (Q_END)
    ) u_wave (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .state_nxt  (state_nxt),
        .sync_pulse (sync_pulse),
        .ref_i      (ref_i),
        .ref_q      (ref_q)
    );

    AST_SYNC_AT_DECODE: assert property (@(posedge clk) disable iff (rst)
        sync_pulse |-> state == ST_DECODE) else $error("sync outside decode"); // R7

    AST_STRETCH_QUIET: assert property (@(posedge clk) disable iff (rst)
        state == ST_STRETCH |-> (!sync_pulse && !ref_i && !ref_q)) else $error("stretch outputs active"); // R10

endmodule

// File: tb/mrx_symbol_timer_test.sv
module mrx_symbol_timer_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0;
    logic [1:0] rate_adj = 2'b00;
    logic       sync_pulse;
    logic       ref_i;
    logic       ref_q;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    mrx_symbol_timer uut (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .rate_adj   (rate_adj),
        .sync_pulse (sync_pulse),
        .ref_i      (ref_i),
        .ref_q      (ref_q)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // ticks until sync_pulse is seen high; -1 on timeout
    task automatic ticks_to_sync(output int n);
        n = -1;
        for (int k = 1; k <= 100; k++) begin
            tick();
            if (sync_pulse) begin
                n = k;
                break;
            end
        end
        if (n < 0) check(1'b0, "sync timeout", 0, 1);
    endtask

    task automatic test_reset_state();
        rst = 1'b1; en = 1'b0;
        tick(); tick();
        check({sync_pulse, ref_i, ref_q} == 3'b000, "R1 reset outputs", {sync_pulse, ref_i, ref_q}, 0);
        rst = 1'b0; en = 1'b1;
    endtask

    task automatic test_period(input logic [1:0] code, input int exp_len, input string tag);
        int n;
        rate_adj = code;
        ticks_to_sync(n);
        ticks_to_sync(n);
        check(n == exp_len, tag, n, exp_len);
    endtask

    task automatic test_wave(input logic [1:0] code, input int sym_len);
        int n;
        rate_adj = code;
        ticks_to_sync(n);
        for (int k = 1; k <= sym_len; k++) begin
            tick();
            if (k == sym_len) begin
                check({sync_pulse, ref_i, ref_q} == 3'b100, "R7 decode outputs", {sync_pulse, ref_i, ref_q}, 4);
            end else if (k > 15) begin
                check({sync_pulse, ref_i, ref_q} == 3'b000, "R10 stretch outputs", {sync_pulse, ref_i, ref_q}, 0);
            end else begin
                int p;
                bit ei;
                bit eq;
                p  = k - 1;
                ei = (p < 8);
                eq = (p >= 4) && (p < 12);
                check(ref_i == ei, "R8 ref_i position", ref_i, ei);
                check(ref_q == eq, "R9 ref_q position", ref_q, eq);
                check(sync_pulse == 1'b0, "R7 no sync in body", sync_pulse, 0);
            end
        end
    endtask

    task automatic test_mid_change();
        int n;
        rate_adj = 2'b01;
        ticks_to_sync(n);
        tick();
        rate_adj = 2'b10;
        ticks_to_sync(n);
        check(n == 16, "R6 mid-symbol change ignored", n + 1, 17);
        ticks_to_sync(n);
        check(n == 15, "R6 new code used next symbol", n, 15);
        rate_adj = 2'b00;
    endtask

    task automatic test_enable_gap();
        int n;
        logic si;
        logic sq;
        rate_adj = 2'b00;
        ticks_to_sync(n);
        tick(); tick(); tick();
        en = 1'b0;
        si = ref_i; sq = ref_q;
        for (int k = 0; k < 5; k++) begin
            tick();
            check(ref_i == si && ref_q == sq, "R2 refs hold", {ref_i, ref_q}, {si, sq});
            check(sync_pulse == 1'b0, "R2 no sync idle", sync_pulse, 0);
        end
        en = 1'b1;
        ticks_to_sync(n);
        check(n == 13, "R2 count resumes", n, 13);
    endtask

    task automatic test_reset_mid();
        int n;
        rate_adj = 2'b01;
        ticks_to_sync(n);
        tick();
        rate_adj = 2'b00;
        tick(); tick(); tick();
        rst = 1'b1;
        tick();
        check({sync_pulse, ref_i, ref_q} == 3'b000, "R1 mid reset outputs", {sync_pulse, ref_i, ref_q}, 0);
        rst = 1'b0;
        ticks_to_sync(n);
        check(n == 15, "R1 nominal length after reset", n, 15);
    endtask

    initial begin
        test_reset_state();
        test_period(2'b00, 16, "R3 code 00 period");
        test_period(2'b11, 16, "R3 code 11 period");
        test_period(2'b01, 17, "R4 code 01 period");
        test_period(2'b10, 15, "R5 code 10 period");
        test_wave(2'b00, 16);
        test_wave(2'b01, 17);
        test_wave(2'b10, 15);
        test_mid_change();
        test_enable_gap();
        test_reset_mid();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            check(1'b0, "watchdog expired", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule